// File: doc/BRIEF.md
# Fast/Normal Prioritized Interrupt Controller

This block collects 32 level-sensitive interrupt lines, one per priority level, and turns them into two request classes for a processor core: fast and normal. Two enable registers route each level into one class, into both, or into neither. Two read-only pending registers show the result of that routing after the threshold mask is applied. A fast request always wins over any normal request, whatever their levels. A small three-state machine (`ST_IDLE`, `ST_NORM`, `ST_FAST`) registers the arbitration result. It drives the registered request outputs and a 6-bit vector. A pair of combinational request lines is also provided so that the core can be woken while its clocks are stopped.

The controller has no edge detection. Each source holds its line high until its own service routine clears it, and a pending bit drops only when the line drops. A threshold mask can suppress all levels at or below a chosen level. A class-select bit decides whether the mask acts on normal requests, or on fast requests with every normal request blocked. An autovector bit, set at reset, replaces the level-based vector with a fixed code for each class.

State transitions, evaluated on every clock:
- `IDLE_TO_NORM`: some normal request is pending and no fast request is pending.
- `IDLE_TO_FAST` and `NORM_TO_FAST` (preemption): some fast request is pending.
- `FAST_TO_NORM`: the fast requests are gone and a normal request remains.
- `ANY_TO_IDLE`: nothing is pending.
- Otherwise the state holds.

Top module: `fnic_top`

## Requirements
- R1: After reset the control register reads 1 (autovector on, masking off, class-select 0, threshold 0). Both enable registers read 0. Both request outputs are low and the vector is 0.
- R2: The register at address 4 reads `src & fast_en` and the register at address 5 reads `src & norm_en`. Here `fast_en` is at address 1 and `norm_en` is at address 2. When masking is off, a level with both enables set shows pending in both registers.
- R3: Any pending fast request wins over every normal request, even one at a higher level. When a fast request arrives while `norm_req_o` is high, `norm_req_o` goes low in the same cycle that `fast_req_o` rises.
- R4: Pending bits follow the source level and clear only when the source drops. Writes to the read-only addresses 3 (raw sources), 4, 5 and 6 change nothing.
- R5: Control register layout: bit 0 is autovector, bit 1 is mask enable, bit 2 is class-select, and bits 7:3 are the threshold. With mask enable set and class-select 0, normal pending bits at levels less than or equal to the threshold read 0, and fast pending bits are unaffected.
- R6: With mask enable set and class-select 1, fast pending bits at levels less than or equal to the threshold read 0, and every normal pending bit reads 0.
- R7: With mask enable clear, the threshold and class-select have no effect on pending bits.
- R8: With autovector clear, the vector is `{class, level}`. The class bit (bit 5) is 1 for fast, and the level is the highest pending level of the winning class. The vector and the request outputs change one clock after the pending change. When nothing is pending, the vector is 0 and both requests are low.
- R9: With autovector set, the vector is 1 while a fast request is active and 0 while a normal request is active.
- R10: `raw_fast_o` and `raw_norm_o` are combinational. They reflect the pending state in the same cycle, with `raw_norm_o` held low whenever any fast request is pending.
- R11: The status register at address 6 reads the vector in bits 5:0, `fast_req_o` in bit 6 and `norm_req_o` in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level-sensitive interrupt lines, bit n is level n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| fast_req_o | output | 1 | Registered fast request to core |
| norm_req_o | output | 1 | Registered normal request to core |
| vector_o | output | 6 | Registered vector number |
| raw_fast_o | output | 1 | Unregistered fast request for wake-up |
| raw_norm_o | output | 1 | Unregistered normal request for wake-up |

## Verification
The hardest case to reach from the ports is the `NORM_TO_FAST` preemption, in which a registered normal request is already active when a fast request appears. The bench first raises a normal-only level and waits until `norm_req_o` is high. It then raises a lower level that is enabled only for the fast class. It checks that the raw fast line responds in the same cycle, and that on the next clock the normal request is replaced by the fast one. The class-select masking cases are reached by programming the control register between source patterns. Each case is then read back through the pending registers.

// File: rtl/fnic_pkg.sv
package fnic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_FAST = 2'd2
    } fnic_state_e;

    localparam logic [2:0] ADR_CTRL    = 3'd0;
    localparam logic [2:0] ADR_FEN     = 3'd1;
    localparam logic [2:0] ADR_NEN     = 3'd2;
    localparam logic [2:0] ADR_RAW     = 3'd3;
    localparam logic [2:0] ADR_FPEND   = 3'd4;
    localparam logic [2:0] ADR_NPEND   = 3'd5;
    localparam logic [2:0] ADR_STATUS  = 3'd6;

    localparam int CTRL_AV_BIT  = 0;
    localparam int CTRL_ME_BIT  = 1;
    localparam int CTRL_SEL_BIT = 2;
    localparam int CTRL_LVL_LSB = 3;

endpackage

// File: rtl/fnic_regs.sv
module fnic_regs
    import fnic_pkg::*;
#(
    parameter int NUM_LVL = 32,
    localparam int LVL_W  = $clog2(NUM_LVL),
    localparam int VEC_W  = LVL_W + 1,
    localparam int CTRL_W = CTRL_LVL_LSB + LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [2:0]         addr_i,
    input  logic [NUM_LVL-1:0] wdata_i,
    output logic [NUM_LVL-1:0] rdata_o,
    input  logic [NUM_LVL-1:0] src_i,
    input  logic [NUM_LVL-1:0] fpend_i,
    input  logic [NUM_LVL-1:0] npend_i,
    input  logic [VEC_W-1:0]   vec_i,
    input  logic               freq_i,
    input  logic               nreq_i,
    output logic [NUM_LVL-1:0] fen_o,
    output logic [NUM_LVL-1:0] nen_o,
    output logic               autovec_o,
    output logic               mask_en_o,
    output logic               mask_sel_o,
    output logic [LVL_W-1:0]   mask_lvl_o
);

    logic [CTRL_W-1:0]  ctrl_q;
    logic [NUM_LVL-1:0] fen_q;
    logic [NUM_LVL-1:0] nen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_W'(1);
            fen_q  <= '0;
            nen_q  <= '0;
        end else if (wr_i) begin
            unique case (addr_i)
                ADR_CTRL: ctrl_q <= wdata_i[CTRL_W-1:0];
                ADR_FEN:  fen_q  <= wdata_i;
                ADR_NEN:  nen_q  <= wdata_i;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADR_CTRL:   rdata_o = NUM_LVL'(ctrl_q);
            ADR_FEN:    rdata_o = fen_q;
            ADR_NEN:    rdata_o = nen_q;
            ADR_RAW:    rdata_o = src_i;
            ADR_FPEND:  rdata_o = fpend_i;
            ADR_NPEND:  rdata_o = npend_i;
            ADR_STATUS: rdata_o = NUM_LVL'({nreq_i, freq_i, vec_i});
            default:    rdata_o = '0;
        endcase
    end

    assign fen_o      = fen_q;
    assign nen_o      = nen_q;
    assign autovec_o  = ctrl_q[CTRL_AV_BIT];
    assign mask_en_o  = ctrl_q[CTRL_ME_BIT];
    assign mask_sel_o = ctrl_q[CTRL_SEL_BIT];
    assign mask_lvl_o = ctrl_q[CTRL_LVL_LSB +: LVL_W];

endmodule

// File: rtl/fnic_mask.sv
module fnic_mask #(
    parameter int NUM_LVL = 32,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] src_i,
    input  logic [NUM_LVL-1:0] fen_i,
    input  logic [NUM_LVL-1:0] nen_i,
    input  logic               mask_en_i,
    input  logic               mask_sel_i,
    input  logic [LVL_W-1:0]   mask_lvl_i,
    output logic [NUM_LVL-1:0] fpend_o,
    output logic [NUM_LVL-1:0] npend_o
);

    logic [NUM_LVL-1:0] below;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_thr
        assign below[g] = mask_en_i && (mask_lvl_i >= LVL_W'(g));
    end

    always_comb begin
        if (mask_en_i && mask_sel_i) begin
            fpend_o = src_i & fen_i & ~below;
            npend_o = '0;
        end else begin
            fpend_o = src_i & fen_i;
            npend_o = src_i & nen_i & ~below;
        end
    end

    AST_PEND_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ((fpend_o | npend_o) & ~src_i) == '0); // R4
    AST_SEL_BLOCKS_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en_i && mask_sel_i) |-> (npend_o == '0)); // R6

endmodule

// File: rtl/fnic_prio_enc.sv
module fnic_prio_enc #(
    parameter int NUM_LVL = 32,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] req_i,
    output logic               any_o,
    output logic [LVL_W-1:0]   idx_o
);

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < NUM_LVL; k++) begin
            if (req_i[k]) idx_o = LVL_W'(k);
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/fnic_top.sv
module fnic_top
    import fnic_pkg::*;
#(
    parameter int NUM_LVL = 32,
    localparam int LVL_W  = $clog2(NUM_LVL),
    localparam int VEC_W  = LVL_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] src_i,
    input  logic               reg_wr_i,
    input  logic [2:0]         reg_addr_i,
    input  logic [NUM_LVL-1:0] reg_wdata_i,
    output logic [NUM_LVL-1:0] reg_rdata_o,
    output logic               fast_req_o,
    output logic               norm_req_o,
    output logic [VEC_W-1:0]   vector_o,
    output logic               raw_fast_o,
    output logic               raw_norm_o
);

    logic [NUM_LVL-1:0] fen, nen, fpend, npend;
    logic               autovec, mask_en, mask_sel;
    logic [LVL_W-1:0]   mask_lvl, fidx, nidx;
    logic               fany, nany;
    fnic_state_e        state_q, state_d;
    logic [VEC_W-1:0]   vec_q, vec_d;

    fnic_regs #(.NUM_LVL(NUM_LVL)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o),
        .src_i(src_i), .fpend_i(fpend), .npend_i(npend),
        .vec_i(vec_q), .freq_i(fast_req_o), .nreq_i(norm_req_o),
        .fen_o(fen), .nen_o(nen),
        .autovec_o(autovec), .mask_en_o(mask_en),
        .mask_sel_o(mask_sel), .mask_lvl_o(mask_lvl)
    );

    fnic_mask #(.NUM_LVL(NUM_LVL)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .src_i(src_i), .fen_i(fen), .nen_i(nen),
        .mask_en_i(mask_en), .mask_sel_i(mask_sel), .mask_lvl_i(mask_lvl),
        .fpend_o(fpend), .npend_o(npend)
    );

    fnic_prio_enc #(.NUM_LVL(NUM_LVL)) u_enc_fast (
        .req_i(fpend), .any_o(fany), .idx_o(fidx)
    );

    fnic_prio_enc #(.NUM_LVL(NUM_LVL)) u_enc_norm (
        .req_i(npend), .any_o(nany), .idx_o(nidx)
    );

    // Next state and next vector
    always_comb begin
        if (fany)      state_d = ST_FAST;
        else if (nany) state_d = ST_NORM;
        else           state_d = ST_IDLE;

        unique case (state_d)
            ST_FAST: vec_d = autovec ? VEC_W'(1) : {1'b1, fidx};
            ST_NORM: vec_d = autovec ? VEC_W'(0) : {1'b0, nidx};
            default: vec_d = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
        end
    end

    // Outputs
    always_comb begin
        fast_req_o = 1'b0;
        norm_req_o = 1'b0;
        unique case (state_q)
            ST_FAST: fast_req_o = 1'b1;
            ST_NORM: norm_req_o = 1'b1;
            default: ;
        endcase
    end

    assign vector_o   = vec_q;
    assign raw_fast_o = fany;
    assign raw_norm_o = nany && !fany;

    AST_FAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        raw_fast_o |=> (fast_req_o && !norm_req_o)); // R3
    AST_NORM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        raw_norm_o |=> norm_req_o); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_req_o && !norm_req_o) |-> (vector_o == '0)); // R8
    AST_AUTOVEC_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_req_o && $past(autovec)) |-> (vector_o == VEC_W'(1))); // R9
    AST_RAW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw_fast_o && raw_norm_o)); // R10

endmodule

// File: tb/fnic_top_tb.sv
module fnic_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        freq, nreq, rfast, rnorm;
    logic [5:0]  vec;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    fnic_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .fast_req_o(freq), .norm_req_o(nreq), .vector_o(vec),
        .raw_fast_o(rfast), .raw_norm_o(rnorm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_src(input logic [31:0] s);
        @(negedge clk);
        src = s;
        #1;
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rreg(3'd0, d); chk("R1 ctrl", d, 32'h1);
        rreg(3'd1, d); chk("R1 fast_en", d, 32'h0);
        rreg(3'd2, d); chk("R1 norm_en", d, 32'h0);
        chk("R1 req", {30'd0, freq, nreq}, 32'h0);
        chk("R1 vec", {26'd0, vec}, 32'h0);
    endtask

    task automatic t_pending;
        logic [31:0] d;
        wreg(3'd0, 32'h0);
        wreg(3'd1, 32'h0000_00F0);
        wreg(3'd2, 32'h0000_0F30);
        set_src(32'h0000_0131);
        rreg(3'd4, d); chk("R2 fpend", d, 32'h0000_0030);
        rreg(3'd5, d); chk("R2 npend both", d, 32'h0000_0130);
        set_src(32'h0);
        tick;
    endtask

    task automatic t_preempt;
        wreg(3'd1, 32'h0000_0004);
        wreg(3'd2, 32'h4000_0020);
        set_src(32'h0000_0020);
        chk("R10 raw norm", {30'd0, rfast, rnorm}, 32'h1);
        tick;
        chk("R8 norm req", {30'd0, freq, nreq}, 32'h1);
        chk("R8 norm vec", {26'd0, vec}, 32'd5);
        set_src(32'h4000_0024);
        chk("R10 raw fast same cycle", {30'd0, rfast, rnorm}, 32'h2);
        chk("R3 still norm before edge", {30'd0, freq, nreq}, 32'h1);
        tick;
        chk("R3 fast preempts", {30'd0, freq, nreq}, 32'h2);
        chk("R3 fast vec beats lvl30", {26'd0, vec}, 32'd34);
        set_src(32'h4000_0000);
        tick;
        chk("R8 back to norm", {26'd0, nreq, freq, vec}, {24'd0, 2'b10, 6'd30});
        set_src(32'h0);
        tick;
        chk("R8 idle", {24'd0, nreq, freq, vec}, 32'h0);
    endtask

    task automatic t_ro_level;
        logic [31:0] d;
        wreg(3'd1, 32'h0000_0300);
        set_src(32'h0000_0300);
        wreg(3'd4, 32'hFFFF_FFFF);
        wreg(3'd3, 32'h0);
        wreg(3'd6, 32'hFFFF_FFFF);
        rreg(3'd4, d); chk("R4 ro fpend", d, 32'h0000_0300);
        rreg(3'd3, d); chk("R4 ro raw", d, 32'h0000_0300);
        rreg(3'd1, d); chk("R4 fen kept", d, 32'h0000_0300);
        set_src(32'h0000_0100);
        rreg(3'd4, d); chk("R4 level drop", d, 32'h0000_0100);
        set_src(32'h0);
        tick;
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wreg(3'd1, 32'h0000_0008);
        wreg(3'd2, 32'hFFFF_FFFF);
        wreg(3'd0, (32'd10 << 3) | 32'h2);
        set_src(32'h0000_0C08);
        rreg(3'd5, d); chk("R5 norm masked", d, 32'h0000_0800);
        rreg(3'd4, d); chk("R5 fast unmasked", d, 32'h0000_0008);
        wreg(3'd1, 32'hFFFF_FFFF);
        wreg(3'd0, (32'd10 << 3) | 32'h6);
        rreg(3'd4, d); chk("R6 fast masked", d, 32'h0000_0800);
        rreg(3'd5, d); chk("R6 norm all masked", d, 32'h0);
        wreg(3'd0, (32'd10 << 3) | 32'h4);
        rreg(3'd4, d); chk("R7 fast no mask", d, 32'h0000_0C08);
        rreg(3'd5, d); chk("R7 norm no mask", d, 32'h0000_0C08);
        set_src(32'h0);
        tick;
    endtask

    task automatic t_autovec;
        logic [31:0] d;
        wreg(3'd0, 32'h1);
        wreg(3'd1, 32'h0000_1000);
        wreg(3'd2, 32'h0000_0200);
        set_src(32'h0000_0200);
        tick;
        chk("R9 norm code", {24'd0, nreq, freq, vec}, {24'd0, 2'b10, 6'd0});
        rreg(3'd6, d); chk("R11 status norm", d, 32'h80);
        set_src(32'h0000_1200);
        tick;
        chk("R9 fast code", {24'd0, nreq, freq, vec}, {24'd0, 2'b01, 6'd1});
        rreg(3'd6, d); chk("R11 status fast", d, 32'h41);
        wreg(3'd0, 32'h0);
        tick;
        rreg(3'd6, d); chk("R11 status vec", d, 32'h40 | 32'd44);
        set_src(32'h0);
        tick;
        rreg(3'd6, d); chk("R8 status idle", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick;
        t_reset;
        t_pending;
        t_preempt;
        t_ro_level;
        t_mask;
        t_autovec;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule